// File: doc/BRIEF.md
# Register Bitfield Operation Unit

The unit applies one of eight bitfield operations to a 32-bit data register taken from a small register file: test, extract unsigned, change, extract signed, clear, find first one, set and insert. A field is given by a bit offset and a width, and each of the two comes either from an immediate in a 16-bit extension word or from another register. Offset 0 names the most significant bit. The field runs toward the least significant bit and wraps from bit 0 back to bit 31.

Each operation produces three things. The first is a new value for the target register. The second is a new value for a second register, the one the extension word selects; it receives extract results, receives the find-first-one position, or supplies the insert source. The third is the N and Z condition flags. The datapath is combinational. A small control machine registers the result and raises a one-cycle valid strobe for every accepted request.

The machine has two named states. ST_IDLE goes to ST_DONE when `start` is high and otherwise stays in ST_IDLE. ST_DONE stays in ST_DONE when `start` is high and otherwise goes back to ST_IDLE. `valid` is high exactly while the machine is in ST_DONE.

Top module: `bf_unit`

## Requirements
- R1: A request is sampled on a rising edge when `start` is high. Its results appear on the outputs after that edge and `valid` is high for that cycle. `valid` is low after any edge at which `start` was low, and the outputs keep their last values.
- R2: When `ext[11]` is 1, the offset is the register indexed by `ext[8:6]`, taken modulo 32. When `ext[11]` is 0, the offset is the immediate `ext[10:6]`.
- R3: When `ext[5]` is 1, the width comes from the register indexed by `ext[2:0]`. When `ext[5]` is 0, the width is the immediate `ext[4:0]`. Only the low five bits count in either case, and a value of 0 means a width of 32.
- R4: With offset o and width w, field bit i (for i from 0 to w-1) is register bit 31-((o+i) mod 32). Field bit 0 is the most significant bit of the field.
- R5: For every operation except insert, N is field bit 0 and Z is 1 exactly when all w field bits are 0.
- R6: Operation 1 (extract unsigned) writes the field, zero-extended and right-justified, to the register selected by `ext[14:12]`.
- R7: Operation 3 (extract signed) writes the field, right-justified and sign-extended from field bit 0, to the register selected by `ext[14:12]`.
- R8: Operation 2 inverts the field bits of the target register, operation 4 clears them and operation 6 sets them. In all three, bits outside the field are unchanged.
- R9: Operation 5 (find first one) writes o plus the index i of the first field bit that is 1 to the register selected by `ext[14:12]`. When no field bit is 1, it writes o+w.
- R10: Operation 7 (insert) places the low w bits of the register selected by `ext[14:12]` into the target field, with source bit w-1 at field bit 0. N is source bit w-1, and Z is 1 when those w source bits are all 0.
- R11: Operations 0, 1, 3 and 5 return the target register unchanged. Operations 0, 2, 4, 6 and 7 return the `ext[14:12]` register unchanged.
- R12: After reset `valid`, `tgt_out`, `aux_out`, `flag_n` and `flag_z` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, one operation per cycle |
| op | input | 3 | Operation code (0 test, 1 extract unsigned, 2 change, 3 extract signed, 4 clear, 5 find first one, 6 set, 7 insert) |
| ext | input | 16 | Extension word: offset, width and register selects |
| tgt_sel | input | 3 | Index of the target register |
| rf_data | input | NREG*32 | Register file contents, register k at bits [32k+31:32k] |
| valid | output | 1 | Result strobe |
| tgt_out | output | 32 | New value of the target register |
| aux_out | output | 32 | New value of the register selected by ext[14:12] |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions take `op`, `ext`, `tgt_sel` and `rf_data` to be meaningful only in a cycle where `start` is high. They compare the registered outputs with the decoded offset, width, mask and register reads from that cycle. The bench therefore changes all inputs on the falling clock edge and holds them across the sampling edge. It never changes the register file between a request and its result. It sweeps every operation against every immediate offset and width. It then covers register-sourced offsets and widths with values above 31 and with zero, which exercise the modulo and the width-of-32 rule.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int DW = 32;
    localparam int OW = $clog2(DW);

    typedef enum logic [2:0] {
        OP_TST  = 3'd0,
        OP_EXTU = 3'd1,
        OP_CHG  = 3'd2,
        OP_EXTS = 3'd3,
        OP_CLR  = 3'd4,
        OP_FFO  = 3'd5,
        OP_SET  = 3'd6,
        OP_INS  = 3'd7
    } bf_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } bf_state_e;

    typedef struct packed {
        logic [DW-1:0] tgt;
        logic [DW-1:0] aux;
        logic          n;
        logic          z;
    } bf_res_t;
endpackage

// File: rtl/bf_decode.sv
module bf_decode
    import bf_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic [15:0]        ext,
    input  logic [IW-1:0]      tgt_sel,
    input  logic [NREG*DW-1:0] rf_data,
    output logic [OW-1:0]      fld_off,
    output logic [OW:0]        fld_w,
    output logic [DW-1:0]      tgt_val,
    output logic [DW-1:0]      aux_val
);
    logic [OW-1:0] w_raw;
    logic [OW-1:0] w_m1;

    always_comb begin
        tgt_val = rf_data[tgt_sel*DW +: DW];
        aux_val = rf_data[ext[12 +: IW]*DW +: DW];
        // R2: register offset keeps only its low bits (mod 32)
        if (ext[11])
            fld_off = rf_data[ext[6 +: IW]*DW +: OW];
        else
            fld_off = ext[6 +: OW];
        // R3: width field 0 wraps to full width
        if (ext[5])
            w_raw = rf_data[ext[0 +: IW]*DW +: OW];
        else
            w_raw = ext[0 +: OW];
        w_m1  = w_raw - 1'b1;
        fld_w = {1'b0, w_m1} + 1'b1;
    end
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath
    import bf_pkg::*;
(
    input  bf_op_e         op,
    input  logic [OW-1:0]  fld_off,
    input  logic [OW:0]    fld_w,
    input  logic [DW-1:0]  tgt_val,
    input  logic [DW-1:0]  aux_val,
    output logic [DW-1:0]  fld_mask,
    output bf_res_t        res
);
    logic [OW:0]     sh;
    logic [DW-1:0]   m_left;
    logic [2*DW-1:0] dbl;
    logic [DW-1:0]   lj;
    logic [DW-1:0]   ins_lj;
    logic [DW-1:0]   ins_pos;
    logic [DW-1:0]   ext_u;
    logic [DW-1:0]   ext_s;
    logic [DW-1:0]   ffo_val;
    logic [OW:0]     ffo_idx;
    logic            found;

    always_comb begin
        sh     = (OW+1)'(DW) - fld_w;
        m_left = {DW{1'b1}} << sh;
        // R4: rotate the left-aligned mask right by the offset
        dbl      = {m_left, m_left} >> fld_off;
        fld_mask = dbl[DW-1:0];
        dbl      = {tgt_val & fld_mask, tgt_val & fld_mask} << fld_off;
        lj       = dbl[2*DW-1:DW];
        ins_lj   = aux_val << sh;
        dbl      = {ins_lj, ins_lj} >> fld_off;
        ins_pos  = dbl[DW-1:0];
        ext_u    = lj >> sh;
        ext_s    = DW'($signed(lj) >>> sh);

        found   = 1'b0;
        ffo_idx = fld_w;
        for (int i = 0; i < DW; i++) begin
            if (!found && (i < int'(fld_w)) && lj[DW-1-i]) begin
                found   = 1'b1;
                ffo_idx = (OW+1)'(i);
            end
        end
        ffo_val = DW'(fld_off) + DW'(ffo_idx);

        res.tgt = tgt_val;
        res.aux = aux_val;
        res.n   = lj[DW-1];
        res.z   = (lj == '0);
        unique case (op)
            OP_TST:  ;
            OP_EXTU: res.aux = ext_u;
            OP_CHG:  res.tgt = tgt_val ^ fld_mask;
            OP_EXTS: res.aux = ext_s;
            OP_CLR:  res.tgt = tgt_val & ~fld_mask;
            OP_FFO:  res.aux = ffo_val;
            OP_SET:  res.tgt = tgt_val | fld_mask;
            OP_INS: begin
                res.tgt = (tgt_val & ~fld_mask) | ins_pos;
                res.n   = ins_lj[DW-1];
                res.z   = (ins_lj == '0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bf_unit.sv
module bf_unit
    import bf_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         op,
    input  logic [15:0]        ext,
    input  logic [IW-1:0]      tgt_sel,
    input  logic [NREG*DW-1:0] rf_data,
    output logic               valid,
    output logic [DW-1:0]      tgt_out,
    output logic [DW-1:0]      aux_out,
    output logic               flag_n,
    output logic               flag_z
);
    bf_state_e     state_q, state_d;
    bf_op_e        op_e, op_q;
    logic [OW-1:0] fld_off;
    logic [OW:0]   fld_w;
    logic [DW-1:0] tgt_val, aux_val, fld_mask;
    bf_res_t       res;

    assign op_e = bf_op_e'(op);

    bf_decode #(.NREG(NREG)) u_dec (
        .ext(ext), .tgt_sel(tgt_sel), .rf_data(rf_data),
        .fld_off(fld_off), .fld_w(fld_w), .tgt_val(tgt_val), .aux_val(aux_val)
    );

    bf_datapath u_dp (
        .op(op_e), .fld_off(fld_off), .fld_w(fld_w), .tgt_val(tgt_val),
        .aux_val(aux_val), .fld_mask(fld_mask), .res(res)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_out <= '0;
            aux_out <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            op_q    <= OP_TST;
        end else if (start) begin
            tgt_out <= res.tgt;
            aux_out <= res.aux;
            flag_n  <= res.n;
            flag_z  <= res.z;
            op_q    <= op_e;
        end
    end

    assign valid = (state_q == ST_DONE);

    assert_valid_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!valid && $stable(tgt_out) && $stable(aux_out)));
    assert_target_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op_e == OP_TST || op_e == OP_EXTU || op_e == OP_EXTS || op_e == OP_FFO))
        |=> (tgt_out == $past(tgt_val)));
    assert_extu_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_e == OP_EXTU) |=> ((64'(aux_out) >> $past(fld_w)) == 64'd0));
    assert_extu_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op_q == OP_EXTU) |-> (flag_z == (aux_out == '0)));
    assert_set_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_e == OP_SET) |=> ((tgt_out & $past(fld_mask)) == $past(fld_mask)));
    assert_clr_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_e == OP_CLR) |=> ((tgt_out & $past(fld_mask)) == '0));
    assert_ffo_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op_e == OP_FFO) |=> ((aux_out >= DW'($past(fld_off))) &&
                                       (aux_out <= DW'($past(fld_off)) + DW'($past(fld_w)))));
endmodule

// File: tb/tb_bf_unit.sv
`timescale 1ns/1ps
module tb_bf_unit;
    localparam int NREG = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        op = '0;
    logic [15:0]       ext = '0;
    logic [2:0]        tgt_sel = '0;
    logic [NREG*32-1:0] rf_data;
    logic              valid;
    logic [31:0]       tgt_out, aux_out;
    logic              flag_n, flag_z;

    logic [31:0] rf [NREG];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always_comb
        for (int k = 0; k < NREG; k++) rf_data[k*32 +: 32] = rf[k];

    bf_unit #(.NREG(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ext(ext),
        .tgt_sel(tgt_sel), .rf_data(rf_data), .valid(valid),
        .tgt_out(tgt_out), .aux_out(aux_out), .flag_n(flag_n), .flag_z(flag_z)
    );

    // Reference model from R4..R11, bit by bit
    task automatic model(input int opc, input int o, input int w,
                         input logic [31:0] t, input logic [31:0] s,
                         output logic [31:0] et, output logic [31:0] ea,
                         output logic en, output logic ez);
        logic [31:0] fld = '0;
        int pos;
        int first = -1;
        et = t; ea = s;
        for (int i = 0; i < w; i++) begin
            pos = 31 - ((o + i) % 32);
            fld[31-i] = t[pos];
            if (first < 0 && t[pos]) first = i;
            case (opc)
                2: et[pos] = ~t[pos];
                4: et[pos] = 1'b0;
                6: et[pos] = 1'b1;
                7: et[pos] = s[w-1-i];
                default: ;
            endcase
        end
        en = fld[31];
        ez = (fld == 0);
        case (opc)
            1, 3: begin
                ea = (opc == 3 && fld[31]) ? 32'hFFFF_FFFF : 32'h0;
                for (int i = 0; i < w; i++) ea[w-1-i] = fld[31-i];
            end
            5: ea = o + ((first < 0) ? w : first);
            7: begin
                en = s[w-1];
                ez = 1'b1;
                for (int i = 0; i < w; i++) if (s[i]) ez = 1'b0;
            end
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int opc);
        case (opc)
            0: return "R11";
            1: return "R6";
            3: return "R7";
            5: return "R9";
            7: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input bit ok, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // drive at negedge, sample at following negedge
    task automatic one(input int opc, input logic [15:0] e, input int o, input int w,
                       input string req);
        logic [31:0] et, ea;
        logic en, ez;
        op = 3'(opc); ext = e; start = 1'b1;
        model(opc, o, w, rf[0], rf[1], et, ea, en, ez);
        @(negedge clk);
        check(req, valid && tgt_out == et && aux_out == ea && flag_n == en && flag_z == ez,
              $sformatf("op=%0d o=%0d w=%0d act tgt=%h aux=%h n=%b z=%b v=%b exp tgt=%h aux=%h n=%b z=%b v=1",
                        opc, o, w, tgt_out, aux_out, flag_n, flag_z, valid, et, ea, en, ez));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat_t [2];
        logic [31:0] pat_s [2];
        int offr [6];
        int widr [6];
        pat_t[0] = 32'hA5C3_0F96; pat_s[0] = 32'h1234_5679;
        pat_t[1] = 32'h0000_0100; pat_s[1] = 32'hFFFF_FFFE;
        offr = '{0, 5, 31, 32, 37, -1};
        widr = '{0, 1, 31, 32, 33, 7};
        for (int k = 0; k < NREG; k++) rf[k] = 32'h0;
        tgt_sel = 3'd0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", !valid && tgt_out == 0 && aux_out == 0 && !flag_n && !flag_z,
              $sformatf("act v=%b tgt=%h aux=%h n=%b z=%b exp all 0", valid, tgt_out, aux_out, flag_n, flag_z));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 immediate sweep; aux reg 1 via ext[14:12]
        for (int p = 0; p < 2; p++) begin
            rf[0] = pat_t[p]; rf[1] = pat_s[p];
            for (int opc = 0; opc < 8; opc++)
                for (int o = 0; o < 32; o++)
                    for (int wf = 0; wf < 32; wf++)
                        one(opc, {1'b0, 3'd1, 1'b0, 5'(o), 1'b0, 5'(wf)}, o,
                            (wf == 0) ? 32 : wf, {"R4 R5 ", tag_of(opc)});
        end

        // R2 R3 register-sourced offset (reg 2) and width (reg 3)
        rf[0] = 32'h8001_7E42; rf[1] = 32'h0000_0ACE;
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++) begin
                rf[2] = 32'(offr[a]); rf[3] = 32'(widr[b]);
                for (int opc = 0; opc < 8; opc++)
                    one(opc, {1'b0, 3'd1, 1'b1, 2'b00, 3'd2, 1'b1, 2'b00, 3'd3},
                        offr[a] & 31, ((widr[b] & 31) == 0) ? 32 : (widr[b] & 31),
                        {"R2 R3 ", tag_of(opc)});
            end

        // R1: valid drops when start is low, outputs hold
        begin
            logic [31:0] ht, ha;
            ht = tgt_out; ha = aux_out;
            start = 1'b0;
            rf[0] = 32'hDEAD_BEEF;
            @(negedge clk);
            check("R1", !valid && tgt_out == ht && aux_out == ha,
                  $sformatf("act v=%b tgt=%h aux=%h exp v=0 tgt=%h aux=%h", valid, tgt_out, aux_out, ht, ha));
            @(negedge clk);
            check("R1", !valid, $sformatf("act v=%b exp v=0", valid));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule